// File: doc/BRIEF.md
# Compare Match Timer Channel

This block is one timer channel. A 16-bit up-counter advances on one of four divided enables taken from the peripheral clock. When the count reaches the value in a 16-bit compare register, the channel latches a sticky match flag. It can also raise an interrupt request. On the increment after a match the counter returns to zero, so one match period is (compare + 1) divided ticks.

Software reaches the counter, the compare value, a control/status register and a start register through a simple synchronous register bus. Reads are combinational and writes are taken on the clock edge. The match flag is cleared in one of two ways:
- Software writes 0 to the flag after an earlier read has returned it as 1.
- A transfer controller, serving the match interrupt, returns an acknowledge with its disable-select qualifier low.

A three-state flag machine holds the flag and the "seen set" condition. Its states are:
- `FLAG_CLEAR`: the flag is 0.
- `FLAG_UNSEEN`: the flag is 1 and no read has returned it yet.
- `FLAG_SEEN`: the flag is 1 and a read has returned it as 1.

Its transitions are:
- `match_hit` (counter reached compare): any state moves to `FLAG_UNSEEN`, except `FLAG_SEEN` with no clear, which stays where it is.
- `status_read` (bus read of the control/status register): `FLAG_UNSEEN` moves to `FLAG_SEEN`.
- `sw_clear` (bus write with the flag bit 0): `FLAG_SEEN` moves to `FLAG_CLEAR`.
- `xfer_clear` (acknowledge with the qualifier low): `FLAG_UNSEEN` or `FLAG_SEEN` moves to `FLAG_CLEAR`.

If a clear and a match arrive in the same cycle, the match wins and the next state is `FLAG_UNSEEN`.

Top module: `cmt_channel`

## Requirements
- R1: Register addresses are 0 for control/status, 1 for the counter, 2 for compare and 3 for start (bit 0). In control/status, bit 7 is the match flag, bit 6 is the interrupt enable and bits 1:0 are the rate select. All other bits read as 0 and ignore writes.
- R2: After reset the counter reads 0, compare reads 0xFFFF, control/status reads 0, start reads 0 and `irq` is 0.
- R3: The flag becomes 1 in the same cycle that an increment makes the counter equal to compare. A bus write of 1 to bit 7 never sets it.
- R4: A bus write of 0 to bit 7 clears the flag only if an earlier bus read of control/status returned bit 7 as 1 while the flag was set. Otherwise the write leaves the flag at 1.
- R5: A one-cycle `xfer_ack` with `xfer_dis_sel` = 0 clears the flag. With `xfer_dis_sel` = 1 it has no effect.
- R6: `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R7: Rate select 00, 01, 10 and 11 advance the counter by 1 every 8, 32, 128 and 512 clock cycles.
- R8: With start bit 0 the counter holds its value.
- R9: An increment while the counter equals compare loads 0. Matches therefore recur every (compare + 1) × divisor cycles.
- R10: A bus write to the counter wins over an increment in the same cycle. The written value is read back on the next cycle.
- R11: When a match and a valid clear fall in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is 1 |
| xfer_ack | input | 1 | Transfer-controller completion for this channel's interrupt |
| xfer_dis_sel | input | 1 | Disable-select qualifier of that completion |
| irq | output | 1 | Match interrupt request |

## Verification
A flag machine stuck in `FLAG_UNSEEN` shows as an `irq` that a read-then-write-0 sequence fails to drop on the very next cycle. A machine that reaches `FLAG_SEEN` without a read shows as a flag that a blind write of 0 clears at once. A wrong prescaler tap or a wrong wrap value shows within one match period (at most 512 × 65536 cycles, but tens of cycles with the small compare values used) as a wrong spacing between counter steps or between `irq` rises. Priority faults (write against increment, set against clear) show in the single cycle where the two events meet, so the stimulus sweeps every prescaler phase.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef enum logic [1:0] {
        FLAG_CLEAR  = 2'd0,
        FLAG_UNSEEN = 2'd1,
        FLAG_SEEN   = 2'd2
    } flag_state_t;

    localparam int REG_ADDR_W = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_COUNT = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_CMP   = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_START = 2'd3;

    localparam int FLAG_POS = 7;
    localparam int IE_POS   = 6;

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
    parameter int N_TAPS      = 4,
    parameter int FIRST_SHIFT = 3,
    parameter int STEP        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_TAPS-1:0] tick
);
    localparam int PRE_W = FIRST_SHIFT + STEP * (N_TAPS - 1);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    // one-cycle pulse when the low SH bits are all ones: period 2**SH
    for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
        localparam int SH = FIRST_SHIFT + STEP * i;
        assign tick[i] = &pre_q[SH-1:0];
    end

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         cnt_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cmp_q,
    output logic         match_hit
);
    logic [W-1:0] cnt_next;

    always_comb begin
        if (cnt_q == cmp_q) begin
            cnt_next = '0;
        end else begin
            cnt_next = cnt_q + W'(1);
        end
    end

    // a write replaces the increment, so it also suppresses the match
    assign match_hit = tick_en && !cnt_wr && (cnt_next == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (tick_en) begin
            cnt_q <= cnt_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '1;
        end else if (cmp_wr) begin
            cmp_q <= wdata;
        end
    end

endmodule

// File: rtl/cmt_flag_fsm.sv
module cmt_flag_fsm
    import cmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match_hit,
    input  logic status_read,
    input  logic sw_clear,
    input  logic xfer_clear,
    output logic flag,
    output logic seen
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (match_hit) state_d = FLAG_UNSEEN;
            end
            FLAG_UNSEEN: begin
                if (xfer_clear) begin
                    state_d = match_hit ? FLAG_UNSEEN : FLAG_CLEAR;
                end else if (status_read && !match_hit) begin
                    state_d = FLAG_SEEN;
                end
            end
            FLAG_SEEN: begin
                if (sw_clear || xfer_clear) begin
                    state_d = match_hit ? FLAG_UNSEEN : FLAG_CLEAR;
                end
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = 1'b0;
        seen = 1'b0;
        unique case (state_q)
            FLAG_CLEAR:  ;
            FLAG_UNSEEN: flag = 1'b1;
            FLAG_SEEN: begin
                flag = 1'b1;
                seen = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int N_RATES    = 4,
    parameter int RATE_SHIFT = 3,
    parameter int RATE_STEP  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    output logic [CNT_W-1:0]      bus_rdata,
    input  logic                  xfer_ack,
    input  logic                  xfer_dis_sel,
    output logic                  irq
);
    localparam int SEL_W = $clog2(N_RATES);

    logic             ie_q;
    logic [SEL_W-1:0] cks_q;
    logic             start_q;
    logic [N_RATES-1:0] rate_tick;
    logic             tick_en;
    logic             ctrl_wr;
    logic             cnt_wr;
    logic             cmp_wr;
    logic             start_wr;
    logic [CNT_W-1:0] cnt_val;
    logic [CNT_W-1:0] cmp_val;
    logic             match_hit;
    logic             flag;
    logic             flag_seen;

    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
    assign cnt_wr   = bus_wr && (bus_addr == ADDR_COUNT);
    assign cmp_wr   = bus_wr && (bus_addr == ADDR_CMP);
    assign start_wr = bus_wr && (bus_addr == ADDR_START);

    cmt_prescaler #(
        .N_TAPS      (N_RATES),
        .FIRST_SHIFT (RATE_SHIFT),
        .STEP        (RATE_STEP)
    ) u_prescaler (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (rate_tick)
    );

    assign tick_en = start_q && rate_tick[cks_q];

    cmt_counter #(
        .W(CNT_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .cnt_wr   (cnt_wr),
        .cmp_wr   (cmp_wr),
        .wdata    (bus_wdata),
        .cnt_q    (cnt_val),
        .cmp_q    (cmp_val),
        .match_hit(match_hit)
    );

    cmt_flag_fsm u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .match_hit  (match_hit),
        .status_read(bus_rd && (bus_addr == ADDR_CTRL)),
        .sw_clear   (ctrl_wr && !bus_wdata[FLAG_POS]),
        .xfer_clear (xfer_ack && !xfer_dis_sel),
        .flag       (flag),
        .seen       (flag_seen)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q    <= 1'b0;
            cks_q   <= '0;
            start_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                ie_q  <= bus_wdata[IE_POS];
                cks_q <= bus_wdata[SEL_W-1:0];
            end
            if (start_wr) begin
                start_q <= bus_wdata[0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    bus_rdata[FLAG_POS]  = flag;
                    bus_rdata[IE_POS]    = ie_q;
                    bus_rdata[SEL_W-1:0] = cks_q;
                end
                ADDR_COUNT: bus_rdata = cnt_val;
                ADDR_CMP:   bus_rdata = cmp_val;
                ADDR_START: bus_rdata[0] = start_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign irq = flag && ie_q;

endmodule

// File: rtl/cmt_channel_chk.sv
module cmt_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt_val,
    input logic [W-1:0] cmp_val,
    input logic         flag,
    input logic         flag_seen,
    input logic         start_q,
    input logic         tick_en,
    input logic         cnt_wr,
    input logic         match_hit,
    input logic         xfer_ack,
    input logic         xfer_dis_sel,
    input logic         ie_q,
    input logic         irq
);
    // R3
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && $stable(cmp_val)) |-> (cnt_val == cmp_val));

    // R4
    blind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_seen && !(xfer_ack && !xfer_dis_sel)) |=> flag);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_q && !cnt_wr) |=> $stable(cnt_val));

    // R9
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cnt_wr && (cnt_val == cmp_val)) |=> (cnt_val == '0));

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_hit |=> flag);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q || !flag) |-> !irq);

endmodule

bind cmt_channel cmt_channel_chk #(.W(CNT_W)) u_cmt_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_val     (cnt_val),
    .cmp_val     (cmp_val),
    .flag        (flag),
    .flag_seen   (flag_seen),
    .start_q     (start_q),
    .tick_en     (tick_en),
    .cnt_wr      (cnt_wr),
    .match_hit   (match_hit),
    .xfer_ack    (xfer_ack),
    .xfer_dis_sel(xfer_dis_sel),
    .ie_q        (ie_q),
    .irq         (irq)
);

// File: tb/test_cmt_channel.sv
`timescale 1ns/1ps
module test_cmt_channel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_rd;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        xfer_ack;
    logic        xfer_dis_sel;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    longint cyc_now = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc_now <= cyc_now + 1;

    cmt_channel i_cmt_channel (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .xfer_ack    (xfer_ack),
        .xfer_dis_sel(xfer_dis_sel),
        .irq         (irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input int limit, output longint at);
        at = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            #1;
            if (irq) begin
                at = cyc_now;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        read_reg(2'd0, d); check("R2", "ctrl after reset", d, 16'h0000);
        read_reg(2'd1, d); check("R2", "count after reset", d, 16'h0000);
        read_reg(2'd2, d); check("R2", "compare after reset", d, 16'hFFFF);
        read_reg(2'd3, d); check("R2", "start after reset", d, 16'h0000);
        check("R2", "irq after reset", irq, 1'b0);
    endtask

    task automatic t_reserved();
        logic [15:0] d;
        write_reg(2'd0, 16'hFFFF);
        read_reg(2'd0, d);
        check("R1", "ctrl after all-ones write (flag not set by R3)", d, 16'h0043);
        write_reg(2'd0, 16'h0000);
        read_reg(2'd0, d); check("R1", "ctrl cleared", d, 16'h0000);
    endtask

    task automatic t_hold();
        logic [15:0] d;
        idle(100);
        read_reg(2'd1, d); check("R8", "count idle after reset", d, 16'h0000);
        write_reg(2'd1, 16'h1234);
        idle(600);
        read_reg(2'd1, d); check("R8", "count held while stopped", d, 16'h1234);
    endtask

    task automatic t_rate(input logic [1:0] sel, input int expect_cyc);
        logic [15:0] prev;
        int n;
        write_reg(2'd3, 16'h0000);
        write_reg(2'd2, 16'hFFFF);
        write_reg(2'd1, 16'h0000);
        write_reg(2'd0, {14'd0, sel});
        write_reg(2'd3, 16'h0001);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd1;
        #1 prev = bus_rdata;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk); #1;
            if (bus_rdata != prev) break;
        end
        prev = bus_rdata;
        n = 0;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk); #1;
            n++;
            if (bus_rdata != prev) break;
        end
        check("R7", $sformatf("step spacing sel=%0d", sel), n, expect_cyc);
        check("R7", $sformatf("step size sel=%0d", sel), bus_rdata, prev + 16'd1);
        bus_rd = 1'b0;
        write_reg(2'd3, 16'h0000);
    endtask

    task automatic t_match_wrap();
        logic [15:0] prev;
        logic [15:0] d;
        int over;
        int wraps;
        int irq_hi;
        write_reg(2'd0, 16'h0000);
        write_reg(2'd2, 16'h0003);
        write_reg(2'd1, 16'h0000);
        write_reg(2'd3, 16'h0001);
        irq_hi = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            if (irq) irq_hi++;
        end
        check("R6", "irq with enable 0", irq_hi, 0);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd1;
        #1 prev = bus_rdata;
        over = 0; wraps = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1;
            if (bus_rdata != prev) begin
                if (bus_rdata != ((prev == 16'd3) ? 16'd0 : prev + 16'd1)) over++;
                if (prev == 16'd3) wraps++;
                prev = bus_rdata;
            end
        end
        bus_rd = 1'b0;
        check("R9", "wrong successor values", over, 0);
        check("R9", "wraps 3->0 in 200 cycles", wraps, 6);
        write_reg(2'd3, 16'h0000);
        read_reg(2'd0, d);
        check("R3", "flag set after matches", d, 16'h0080);
    endtask

    task automatic t_clear_rules();
        logic [15:0] d;
        longint t1;
        longint t2;
        write_reg(2'd0, 16'h0040);
        read_reg(2'd0, d);
        check("R4", "flag cleared after read-then-write-0", d, 16'h0040);
        check("R6", "irq low with flag clear", irq, 1'b0);
        write_reg(2'd1, 16'h0000);
        write_reg(2'd3, 16'h0001);
        wait_irq(100, t1);
        check("R6", "irq rises on match with enable 1", irq, 1'b1);
        write_reg(2'd0, 16'h0040);
        #1 check("R4", "blind write 0 keeps flag", irq, 1'b1);
        read_reg(2'd0, d);
        check("R4", "read returns flag", d, 16'h00C0);
        write_reg(2'd0, 16'h00C0);
        #1 check("R3", "write 1 after read has no effect", irq, 1'b1);
        write_reg(2'd0, 16'h0040);
        #1 check("R4", "write 0 after read clears", irq, 1'b0);
        wait_irq(100, t2);
        check("R9", "match spacing cmp=3 div=8", t2 - t1, 32);
        @(negedge clk); xfer_ack = 1'b1; xfer_dis_sel = 1'b1;
        @(negedge clk); xfer_ack = 1'b0;
        #1 check("R5", "ack with qualifier 1 ignored", irq, 1'b1);
        @(negedge clk); xfer_ack = 1'b1; xfer_dis_sel = 1'b0;
        @(negedge clk); xfer_ack = 1'b0;
        #1 check("R5", "ack with qualifier 0 clears", irq, 1'b0);
        write_reg(2'd3, 16'h0000);
    endtask

    task automatic t_write_priority();
        int miss;
        write_reg(2'd2, 16'hFFFF);
        write_reg(2'd0, 16'h0000);
        write_reg(2'd3, 16'h0001);
        miss = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0100 + 16'(i);
            @(negedge clk);
            bus_wr = 1'b0; bus_rd = 1'b1;
            #1 if (bus_rdata != 16'h0100 + 16'(i)) miss++;
            @(negedge clk);
            bus_rd = 1'b0;
        end
        check("R10", "writes lost to increment over 8 phases", miss, 0);
        write_reg(2'd3, 16'h0000);
    endtask

    task automatic t_set_wins();
        int hi;
        write_reg(2'd0, 16'h0040);
        write_reg(2'd2, 16'h0000);
        write_reg(2'd1, 16'h0000);
        @(negedge clk); xfer_ack = 1'b1; xfer_dis_sel = 1'b0;
        write_reg(2'd3, 16'h0001);
        idle(16);
        hi = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk); #1;
            if (irq) hi++;
        end
        check("R11", "flag pulses under held clear", hi, 8);
        xfer_ack = 1'b0;
        write_reg(2'd3, 16'h0000);
    endtask

    initial begin
        rst_n = 1'b0;
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 16'h0;
        xfer_ack = 1'b0; xfer_dis_sel = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reserved();
        t_hold();
        t_rate(2'd0, 8);
        t_rate(2'd1, 32);
        t_rate(2'd2, 128);
        t_rate(2'd3, 512);
        t_match_wrap();
        t_clear_rules();
        t_write_priority();
        t_set_wins();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule